// File: doc/BRIEF.md
# Write-Through Line Cache with Store Snoop

This block is a small direct-mapped cache of 12-bit words that never holds dirty data. A requester presents a 15-bit word address and, in the same cycle, sees either a hit together with the cached word or a miss. On a miss the block offers a line-fill request on a valid/ready port. The requester stalls and presents the lookup again on later cycles until it hits. Line responses come back on a second port that is always ready. Each response is installed whether or not a request is pending for that line.

Stores are written to memory by the pipeline itself. The cache sees each store on a snoop port and patches the stored word only when that line is already resident. A store never allocates a line. A chip normally carries two copies of this block, one serving instruction fetch and one serving operand loads. Both copies snoop every store, so each stays equal to memory without any write-back path.

With the default parameters the cache has 8 sets and lines of 4 words. Address bits [1:0] select the word, bits [4:2] the set, and bits [14:5] form the tag. A line address is the word address shifted right by 2.

Top module: `lc_line_cache`

## Requirements
- R1: After reset every line is invalid, so any lookup reports a miss until a line response installs its line.
- R2: When a lookup's line is resident, `lk_hit` is 1 in the same cycle and `lk_data` equals the cached word at the offset `lk_addr[1:0]`. `lk_hit` is 0 whenever `lk_valid` is 0.
- R3: A lookup that misses raises `req_valid` in the same cycle with `req_line` = `lk_addr[14:2]`. The request stays offered whatever the value of `req_ready`. `req_valid` is 0 when there is no lookup or the lookup hits. The fill request is accepted on a cycle where both `req_valid` and `req_ready` are 1.
- R4: `rsp_ready` is always 1. A response with `rsp_valid` high installs its line at set `rsp_line[2:0]` with tag `rsp_line[12:3]`. Word k of the line is `rsp_data[12k+11:12k]`. Lookups of that line hit from the next cycle.
- R5: A response is installed even when no request for its line is pending, including while a different lookup is missing.
- R6: A store to a resident line replaces only the addressed word, visible from the next cycle. The other words of the line keep their values.
- R7: A store to a line that is not resident changes nothing. The line stays absent, and a resident line with another tag in the same set keeps its data.
- R8: When a response and a store address the same line in the same cycle, the line is installed and the stored word then overrides the returned word at that offset.
- R9: A response to a set that holds a line with another tag replaces that line, so the old line then misses. Other sets are unaffected.
- R10: A lookup made in the same cycle as a response or a store sees the contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears valid bits |
| lk_valid | input | 1 | Lookup present |
| lk_addr | input | 15 | Lookup word address |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_data | output | 12 | Hit data word, 0 on miss |
| req_valid | output | 1 | Line-fill request offered |
| req_ready | input | 1 | Memory accepts the fill request |
| req_line | output | 13 | Line address of the fill request |
| rsp_valid | input | 1 | Line response present |
| rsp_ready | output | 1 | Always 1 |
| rsp_line | input | 13 | Line address of the response |
| rsp_data | input | 48 | Four words of the line, word 0 in the low bits |
| st_valid | input | 1 | Store observed |
| st_addr | input | 15 | Store word address |
| st_data | input | 12 | Store data word |

## Verification
A line response and a store snoop can fall in the same cycle. That case matters when both target one line, and also when the response evicts the line that the store targets. The bench drives both ports on the same clock for a line that was absent and checks the words afterwards: the stored word must win and its neighbours must show the returned data. It then repeats the collision with a response to another tag in the same set, and checks that the old line is gone and the new line is untouched. A lookup made during a fill or a store is also checked, both in that cycle and in the next.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_ADDR_W     = 15;
  localparam int LC_DATA_W     = 12;
  localparam int LC_SETS       = 8;
  localparam int LC_LINE_WORDS = 4;
endpackage

// File: rtl/lc_tag_array.sv
module lc_tag_array #(
  parameter int SETS  = 8,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output logic             a_vld,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output logic             b_vld
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  vld_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(s)) begin
        vld_q[s] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(s)) tag_q[s] <= wr_tag;
    end
  end

  assign a_tag = tag_q[a_idx];
  assign a_vld = vld_q[a_idx];
  assign b_tag = tag_q[b_idx];
  assign b_vld = vld_q[b_idx];
endmodule

// File: rtl/lc_data_array.sv
module lc_data_array #(
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 12,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    fill_en,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [WORDS*DATA_W-1:0] fill_line,
  input  logic                    st_en,
  input  logic [IDX_W-1:0]        st_idx,
  input  logic [OFF_W-1:0]        st_off,
  input  logic [DATA_W-1:0]       st_data,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [OFF_W-1:0]        rd_off,
  output logic [DATA_W-1:0]       rd_data
);
  logic [DATA_W-1:0] mem [SETS][WORDS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      // store is applied after the fill, so it takes priority
      always_ff @(posedge clk) begin
        if (st_en && st_idx == IDX_W'(s) && st_off == OFF_W'(w)) begin
          mem[s][w] <= st_data;
        end else if (fill_en && fill_idx == IDX_W'(s)) begin
          mem[s][w] <= fill_line[w*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign rd_data = mem[rd_idx][rd_off];
endmodule

// File: rtl/lc_line_cache.sv
module lc_line_cache #(
  parameter int ADDR_W     = lc_pkg::LC_ADDR_W,
  parameter int DATA_W     = lc_pkg::LC_DATA_W,
  parameter int SETS       = lc_pkg::LC_SETS,
  parameter int LINE_WORDS = lc_pkg::LC_LINE_WORDS,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_valid,
  input  logic [ADDR_W-1:0]            lk_addr,
  output logic                         lk_hit,
  output logic [DATA_W-1:0]            lk_data,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [LINE_W-1:0]            req_line,
  input  logic                         rsp_valid,
  output logic                         rsp_ready,
  input  logic [LINE_W-1:0]            rsp_line,
  input  logic [LINE_WORDS*DATA_W-1:0] rsp_data,
  input  logic                         st_valid,
  input  logic [ADDR_W-1:0]            st_addr,
  input  logic [DATA_W-1:0]            st_data
);
  logic [OFF_W-1:0]  lk_off, st_off;
  logic [IDX_W-1:0]  lk_idx, st_idx, rsp_idx;
  logic [TAG_W-1:0]  lk_tag, st_tag, rsp_tag;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic              a_vld, b_vld;
  logic              fill_en, st_en, st_resident, st_same_set_fill;
  logic [DATA_W-1:0] rd_word;

  assign lk_off  = lk_addr[OFF_W-1:0];
  assign lk_idx  = lk_addr[OFF_W +: IDX_W];
  assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  assign st_off  = st_addr[OFF_W-1:0];
  assign st_idx  = st_addr[OFF_W +: IDX_W];
  assign st_tag  = st_addr[ADDR_W-1 -: TAG_W];
  assign rsp_idx = rsp_line[IDX_W-1:0];
  assign rsp_tag = rsp_line[LINE_W-1 -: TAG_W];

  // responses are accepted unconditionally
  assign rsp_ready = 1'b1;
  assign fill_en   = rsp_valid;

  lc_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) i_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (fill_en),
    .wr_idx(rsp_idx),
    .wr_tag(rsp_tag),
    .a_idx (lk_idx),
    .a_tag (a_tag),
    .a_vld (a_vld),
    .b_idx (st_idx),
    .b_tag (b_tag),
    .b_vld (b_vld)
  );

  // a fill to the store's set decides residency on its own tag
  assign st_resident      = b_vld && (b_tag == st_tag);
  assign st_same_set_fill = fill_en && (rsp_idx == st_idx);
  assign st_en = st_valid && (st_same_set_fill ? (rsp_tag == st_tag) : st_resident);

  lc_data_array #(.SETS(SETS), .WORDS(LINE_WORDS), .DATA_W(DATA_W)) i_data (
    .clk      (clk),
    .fill_en  (fill_en),
    .fill_idx (rsp_idx),
    .fill_line(rsp_data),
    .st_en    (st_en),
    .st_idx   (st_idx),
    .st_off   (st_off),
    .st_data  (st_data),
    .rd_idx   (lk_idx),
    .rd_off   (lk_off),
    .rd_data  (rd_word)
  );

  assign lk_hit    = lk_valid && a_vld && (a_tag == lk_tag);
  assign lk_data   = lk_hit ? rd_word : '0;
  assign req_valid = lk_valid && !lk_hit;
  assign req_line  = lk_addr[ADDR_W-1:OFF_W];
endmodule

// File: rtl/lc_line_cache_chk.sv
module lc_line_cache_chk #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 12,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         lk_valid,
  input logic [ADDR_W-1:0]            lk_addr,
  input logic                         lk_hit,
  input logic [DATA_W-1:0]            lk_data,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic [LINE_W-1:0]            req_line,
  input logic                         rsp_valid,
  input logic                         rsp_ready,
  input logic [LINE_W-1:0]            rsp_line,
  input logic [LINE_WORDS*DATA_W-1:0] rsp_data,
  input logic                         st_valid,
  input logic [ADDR_W-1:0]            st_addr,
  input logic [DATA_W-1:0]            st_data
);
  // R1: the first cycle out of reset sees no resident line
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit);

  // R2: a hit needs a lookup
  a_r2_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  // R3: a request belongs to the missing lookup's line
  a_r3_req_matches_miss: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (lk_valid && !lk_hit && req_line == lk_addr[ADDR_W-1:OFF_W]));

  // R4: a line that was just returned hits on the next cycle
  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rsp_valid) && lk_valid
     && lk_addr[ADDR_W-1:OFF_W] == $past(rsp_line)) |-> lk_hit);

  // R6 / R8: a word read right after its store shows the stored value
  a_r6_store_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(st_valid) && lk_hit && lk_addr == $past(st_addr))
      |-> lk_data == $past(st_data));

  // R10: with no update in between, a repeated hit returns the same word
  a_r10_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rsp_valid) && !$past(st_valid) && $past(lk_hit)
     && lk_hit && $stable(lk_addr)) |-> $stable(lk_data));
endmodule

bind lc_line_cache lc_line_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
) i_chk (.*);

// File: tb/test_lc_line_cache.sv
module test_lc_line_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [14:0] lk_addr = '0;
  logic        lk_hit;
  logic [11:0] lk_data;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [12:0] req_line;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [12:0] rsp_line = '0;
  logic [47:0] rsp_data = '0;
  logic        st_valid = 1'b0;
  logic [14:0] st_addr = '0;
  logic [11:0] st_data = '0;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;

  always #5 clk = ~clk;

  lc_line_cache i_lc_line_cache (.*);

  typedef struct packed {
    logic [1:0]  op;   // 0 lookup, 1 fill, 2 store
    logic [14:0] addr;
    logic [11:0] dat;
    logic        hit;
    logic [11:0] expd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{2'd0, 15'h0040, 12'h000, 1'b0, 12'h000},  // R3 miss on empty set
    '{2'd1, 15'h0040, 12'h100, 1'b0, 12'h000},  // R4 fill 100..103
    '{2'd0, 15'h0041, 12'h000, 1'b1, 12'h101},
    '{2'd0, 15'h0043, 12'h000, 1'b1, 12'h103},
    '{2'd2, 15'h0042, 12'hABC, 1'b0, 12'h000},  // R6 store resident
    '{2'd0, 15'h0042, 12'h000, 1'b1, 12'hABC},
    '{2'd0, 15'h0041, 12'h000, 1'b1, 12'h101},  // R6 neighbour kept
    '{2'd2, 15'h0060, 12'h555, 1'b0, 12'h000},  // R7 store absent line
    '{2'd0, 15'h0060, 12'h000, 1'b0, 12'h000},  // R7 no allocate
    '{2'd0, 15'h0042, 12'h000, 1'b1, 12'hABC},  // R7 same set untouched
    '{2'd1, 15'h0064, 12'h200, 1'b0, 12'h000},
    '{2'd0, 15'h0065, 12'h000, 1'b1, 12'h201},
    '{2'd1, 15'h0060, 12'h300, 1'b0, 12'h000},  // R9 evict set 0
    '{2'd0, 15'h0040, 12'h000, 1'b0, 12'h000},  // R9 old line gone
    '{2'd0, 15'h0062, 12'h000, 1'b1, 12'h302},
    '{2'd0, 15'h0066, 12'h000, 1'b1, 12'h202},  // R9 other set kept
    '{2'd0, 15'h0060, 12'h000, 1'b1, 12'h300}   // R7 earlier store not kept
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_line(input logic [11:0] base);
    logic [47:0] l;
    for (int k = 0; k < 4; k++) l[k*12 +: 12] = base + 12'(k);
    return l;
  endfunction

  task automatic idle();
    lk_valid = 1'b0; rsp_valid = 1'b0; st_valid = 1'b0; req_ready = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic look(input logic [14:0] a, input logic eh, input logic [11:0] ed, input string req);
    lk_valid = 1'b1; lk_addr = a; #2;
    chk(lk_hit == eh, req, lk_hit, eh);
    if (eh) chk(lk_data == ed, req, lk_data, ed);
    else chk(req_valid && req_line == a[14:2], {req, " req"}, req_line, a[14:2]);
  endtask

  task automatic set_fill(input logic [14:0] a, input logic [11:0] base);
    rsp_valid = 1'b1; rsp_line = a[14:2]; rsp_data = mk_line(base);
  endtask

  task automatic set_store(input logic [14:0] a, input logic [11:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(!lk_hit && !req_valid && rsp_ready, "R1 reset outputs", {lk_hit, req_valid, rsp_ready}, 3'b001);
    look(15'h0040, 1'b0, 12'h0, "R1 empty after reset");
    tick();

    for (int i = 0; i < NV; i++) begin
      case (VT[i].op)
        2'd0: look(VT[i].addr, VT[i].hit, VT[i].expd, VT[i].hit ? "R2 table hit" : "R3 table miss");
        2'd1: set_fill(VT[i].addr, VT[i].dat);
        default: set_store(VT[i].addr, VT[i].dat);
      endcase
      if (VT[i].op != 2'd0) begin
        #2;
        chk(!lk_hit && !req_valid, "R2 idle lookup", {lk_hit, req_valid}, 2'b00);
      end
      tick();
    end

    // R3: back-pressure keeps the request offered
    req_ready = 1'b0;
    look(15'h0150, 1'b0, 12'h0, "R3 stalled request");
    @(posedge clk); @(negedge clk);
    #2;
    chk(req_valid && req_line == 13'h0054, "R3 held under back-pressure", req_line, 13'h0054);
    tick();

    // R8: fill and store to one absent line in the same cycle
    set_fill(15'h00C0, 12'h400);
    set_store(15'h00C1, 12'h777);
    tick();
    look(15'h00C1, 1'b1, 12'h777, "R8 store wins");
    tick();
    look(15'h00C2, 1'b1, 12'h402, "R8 fill neighbour");
    tick();

    // R7: store to the evicted line while a new tag fills its set
    set_fill(15'h0000, 12'h500);
    set_store(15'h00C1, 12'h999);
    tick();
    look(15'h0001, 1'b1, 12'h501, "R7 new line untouched");
    tick();
    look(15'h00C1, 1'b0, 12'h0, "R7 old line gone");
    tick();

    // R10: lookup during its own fill sees the old state
    set_fill(15'h0100, 12'h600);
    look(15'h0100, 1'b0, 12'h0, "R10 miss during fill");
    tick();
    look(15'h0100, 1'b1, 12'h600, "R4 hit after fill");
    tick();

    // R5: unrequested response installed while another lookup misses
    req_ready = 1'b0;
    set_fill(15'h0108, 12'h700);
    look(15'h0104, 1'b0, 12'h0, "R5 other miss");
    tick();
    look(15'h0109, 1'b1, 12'h701, "R5 unrequested install");
    tick();

    // R10: lookup during a store sees the old word, then the new one
    set_store(15'h0101, 12'h0EE);
    look(15'h0101, 1'b1, 12'h601, "R10 old word during store");
    tick();
    look(15'h0101, 1'b1, 12'h0EE, "R6 store visible");
    tick();

    // R1: a second reset empties the cache
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    look(15'h0062, 1'b0, 12'h0, "R1 cleared by reset");
    tick();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule